// File: doc/BRIEF.md
# Video controller status word generator

This block assembles the 16-bit status word that a CPU gets back when it reads the control port of a video controller. It gathers the write-FIFO state, the vertical interrupt and sprite flags, the field parity, the DMA code bit and the region. It also derives the vertical and horizontal blanking indications from the current beam position, comparing it against thresholds that depend on the selected mode. The beam counters and the sprite engine sit elsewhere. Sticky events reach this block as one-cycle set pulses.

A one-cycle read strobe captures the word into an output register and applies the read side effects. The sprite collision flag is cleared after its value has been captured. The command-pending state, which the control-port write logic sets through a pulse, is also cleared. The upper six bits carry an external open-bus value sampled at the read. The PAL/NTSC selection used for the vertical threshold is latched at frame start, so the threshold stays fixed for the whole frame.

Top module: `vstat_word_gen`

## Requirements
- R1: On a read, bits 15:10 of the captured word equal the `open_bus` input sampled in the read cycle.
- R2: Bit 9 is `fifo_empty`. Bit 8 is 1 exactly when the FIFO is not empty and `fifo_wr_ptr` equals `fifo_rd_ptr` (full).
- R3: Bit 7 is `vint_pend` and bit 6 is `sprite_ovf`, both sampled at the read.
- R4: Bit 5 is a sticky collision flag. A `coll_set` pulse sets it. A read returns its value from before that cycle and then clears it, unless `coll_set` is high in the same cycle, in which case it stays set.
- R5: Bit 4 is 1 when `interlace_en` and `field_odd` are both 1.
- R6: Bit 3 is 1 when `disp_en` is 0, or when `line` is at or above the inactive-start line and below 511. The inactive-start line is 192 when `legacy_mode` is 1. Otherwise it is 240 for a latched PAL frame and 224 for NTSC.
- R7: The PAL selection used by R6 is `pal_sel` as sampled on the last `frame_start` pulse (0 after reset). Changes to `pal_sel` between pulses have no effect.
- R8: Bit 2 is 1 when `hslot` is below 10, or above 165 when `wide_mode` is 1, or above 132 when `wide_mode` is 0.
- R9: Bit 1 is `dma_code_bit` and bit 0 is `region_pal`.
- R10: A `cmd_set` pulse raises `cmd_pending`. A read clears it, unless `cmd_set` is high in the same cycle.
- R11: `status_word` and `status_valid` reset to 0. `status_word` loads only in the cycle after a read strobe and holds otherwise. `status_valid` is high for exactly the cycle after each strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_stb | input | 1 | One-cycle control-port read strobe |
| open_bus | input | 6 | Open-bus value for bits 15:10 |
| fifo_empty | input | 1 | Write FIFO holds no entries |
| fifo_wr_ptr | input | PTR_W | FIFO write pointer |
| fifo_rd_ptr | input | PTR_W | FIFO read pointer |
| vint_pend | input | 1 | Vertical interrupt pending |
| sprite_ovf | input | 1 | Sprite overflow flag |
| coll_set | input | 1 | Sprite collision set pulse |
| cmd_set | input | 1 | Command-pending set pulse |
| interlace_en | input | 1 | Interlace enabled |
| field_odd | input | 1 | Current field is odd |
| line | input | LINE_W | Current line |
| hslot | input | SLOT_W | Current horizontal slot |
| legacy_mode | input | 1 | Legacy video mode selected |
| pal_sel | input | 1 | PAL timing selection, latched at frame start |
| frame_start | input | 1 | Frame start pulse |
| disp_en | input | 1 | Display enabled |
| wide_mode | input | 1 | 40-cell width (else 32-cell) |
| dma_code_bit | input | 1 | DMA bit of the access code |
| region_pal | input | 1 | PAL region |
| status_word | output | 16 | Word captured by the last read |
| status_valid | output | 1 | High the cycle after a read strobe |
| cmd_pending | output | 1 | Command-pending state |

## Verification
The assertions assume that `rd_stb`, `coll_set`, `cmd_set` and `frame_start` are synchronous to `clk` and that reset is held for at least one edge. They place no range limit on `line` or `hslot`, because every code has a defined result. The stimulus changes inputs only at falling edges and keeps pulses one cycle wide. It sweeps every line and slot value under each mode, so the comparison boundaries at 10, 132, 165, 192, 224, 240 and 511 are all crossed. It also drives coincident set and read pulses on purpose, to reach the priority rule that the flag assertions rely on.

// File: rtl/vstat_pkg.sv
package vstat_pkg;

    localparam int WORD_W = 16;

    // bit positions of the status word
    localparam int B_BUS_LO = 10;
    localparam int B_EMPTY  = 9;
    localparam int B_FULL   = 8;
    localparam int B_VINT   = 7;
    localparam int B_OVF    = 6;
    localparam int B_COLL   = 5;
    localparam int B_ODD    = 4;
    localparam int B_VBL    = 3;
    localparam int B_HBL    = 2;
    localparam int B_DMA    = 1;
    localparam int B_PAL    = 0;

    typedef struct packed {
        logic pal_frame;
    } blank_state_t;

    typedef struct packed {
        logic coll;
        logic pend;
    } flag_state_t;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              valid;
    } out_state_t;

endpackage

// File: rtl/vstat_blank.sv
module vstat_blank
    import vstat_pkg::*;
#(
    parameter int LINE_W       = 9,
    parameter int SLOT_W       = 9,
    parameter int INACT_LEGACY = 192,
    parameter int INACT_PAL    = 240,
    parameter int INACT_NTSC   = 224,
    parameter int LINE_LIMIT   = 511,
    parameter int HB_END       = 10,
    parameter int HB_START_W   = 165,
    parameter int HB_START_N   = 132
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINE_W-1:0] line,
    input  logic [SLOT_W-1:0] hslot,
    input  logic              legacy_mode,
    input  logic              pal_sel,
    input  logic              frame_start,
    input  logic              disp_en,
    input  logic              wide_mode,
    output logic              vblank,
    output logic              hblank
);

    localparam logic [LINE_W-1:0] L_LEG   = LINE_W'(INACT_LEGACY);
    localparam logic [LINE_W-1:0] L_PAL   = LINE_W'(INACT_PAL);
    localparam logic [LINE_W-1:0] L_NTSC  = LINE_W'(INACT_NTSC);
    localparam logic [LINE_W-1:0] L_LIMIT = LINE_W'(LINE_LIMIT);
    localparam logic [SLOT_W-1:0] S_END   = SLOT_W'(HB_END);
    localparam logic [SLOT_W-1:0] S_WIDE  = SLOT_W'(HB_START_W);
    localparam logic [SLOT_W-1:0] S_NARR  = SLOT_W'(HB_START_N);

    blank_state_t st_q, st_d;
    logic [LINE_W-1:0] inact_line;
    logic [SLOT_W-1:0] hb_start;

    always_comb begin
        st_d = st_q;
        if (frame_start)
            st_d.pal_frame = pal_sel;

        // legacy mode takes precedence over the frame's timing standard
        if (legacy_mode)
            inact_line = L_LEG;
        else if (st_q.pal_frame)
            inact_line = L_PAL;
        else
            inact_line = L_NTSC;

        vblank = !disp_en || ((line >= inact_line) && (line < L_LIMIT));

        hb_start = wide_mode ? S_WIDE : S_NARR;
        hblank   = (hslot < S_END) || (hslot > hb_start);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    // R7: timing standard only moves on a frame start
    p_pal_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(st_q.pal_frame));

    p_pal_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (st_q.pal_frame == $past(pal_sel)));

    // R6: display off always reports vertical blanking
    p_disp_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_en |-> vblank);

endmodule

// File: rtl/vstat_flags.sv
module vstat_flags
    import vstat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd_stb,
    input  logic coll_set,
    input  logic cmd_set,
    output logic coll_flag,
    output logic pend_flag
);

    flag_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        // a read clears; a set in the same cycle wins
        if (rd_stb) begin
            st_d.coll = 1'b0;
            st_d.pend = 1'b0;
        end
        if (coll_set)
            st_d.coll = 1'b1;
        if (cmd_set)
            st_d.pend = 1'b1;
        coll_flag = st_q.coll;
        pend_flag = st_q.pend;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    p_coll_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !coll_set) |=> !st_q.coll);

    p_coll_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.coll && !rd_stb) |=> st_q.coll);

    p_pend_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !cmd_set) |=> !st_q.pend);

    p_pend_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_set |=> st_q.pend);

endmodule

// File: rtl/vstat_word_gen.sv
module vstat_word_gen
    import vstat_pkg::*;
#(
    parameter int PTR_W        = 2,
    parameter int LINE_W       = 9,
    parameter int SLOT_W       = 9,
    parameter int INACT_LEGACY = 192,
    parameter int INACT_PAL    = 240,
    parameter int INACT_NTSC   = 224,
    parameter int LINE_LIMIT   = 511,
    parameter int HB_END       = 10,
    parameter int HB_START_W   = 165,
    parameter int HB_START_N   = 132
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_stb,
    input  logic [5:0]        open_bus,
    input  logic              fifo_empty,
    input  logic [PTR_W-1:0]  fifo_wr_ptr,
    input  logic [PTR_W-1:0]  fifo_rd_ptr,
    input  logic              vint_pend,
    input  logic              sprite_ovf,
    input  logic              coll_set,
    input  logic              cmd_set,
    input  logic              interlace_en,
    input  logic              field_odd,
    input  logic [LINE_W-1:0] line,
    input  logic [SLOT_W-1:0] hslot,
    input  logic              legacy_mode,
    input  logic              pal_sel,
    input  logic              frame_start,
    input  logic              disp_en,
    input  logic              wide_mode,
    input  logic              dma_code_bit,
    input  logic              region_pal,
    output logic [15:0]       status_word,
    output logic              status_valid,
    output logic              cmd_pending
);

    logic vblank, hblank, coll_flag, pend_flag, fifo_full;
    logic [WORD_W-1:0] live_word;
    out_state_t st_q, st_d;

    vstat_blank #(
        .LINE_W(LINE_W), .SLOT_W(SLOT_W),
        .INACT_LEGACY(INACT_LEGACY), .INACT_PAL(INACT_PAL), .INACT_NTSC(INACT_NTSC),
        .LINE_LIMIT(LINE_LIMIT), .HB_END(HB_END),
        .HB_START_W(HB_START_W), .HB_START_N(HB_START_N)
    ) u_blank (
        .clk(clk), .rst_n(rst_n), .line(line), .hslot(hslot),
        .legacy_mode(legacy_mode), .pal_sel(pal_sel), .frame_start(frame_start),
        .disp_en(disp_en), .wide_mode(wide_mode),
        .vblank(vblank), .hblank(hblank)
    );

    vstat_flags u_flags (
        .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb),
        .coll_set(coll_set), .cmd_set(cmd_set),
        .coll_flag(coll_flag), .pend_flag(pend_flag)
    );

    always_comb begin
        fifo_full = !fifo_empty && (fifo_wr_ptr == fifo_rd_ptr);

        live_word                      = '0;
        live_word[WORD_W-1:B_BUS_LO]   = open_bus;
        live_word[B_EMPTY]             = fifo_empty;
        live_word[B_FULL]              = fifo_full;
        live_word[B_VINT]              = vint_pend;
        live_word[B_OVF]               = sprite_ovf;
        live_word[B_COLL]              = coll_flag;
        live_word[B_ODD]               = interlace_en && field_odd;
        live_word[B_VBL]               = vblank;
        live_word[B_HBL]               = hblank;
        live_word[B_DMA]               = dma_code_bit;
        live_word[B_PAL]               = region_pal;

        st_d       = st_q;
        st_d.valid = rd_stb;
        if (rd_stb)
            st_d.word = live_word;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign status_word  = st_q.word;
    assign status_valid = st_q.valid;
    assign cmd_pending  = pend_flag;

    p_bus_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> (status_word[15:10] == $past(open_bus)));

    p_full_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        status_valid |-> !(status_word[B_EMPTY] && status_word[B_FULL]));

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> ($stable(status_word) && !status_valid));

    p_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> status_valid);

endmodule

// File: tb/vstat_word_gen_bench.sv
module vstat_word_gen_bench;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst_n, rd_stb, fifo_empty, vint_pend, sprite_ovf, coll_set, cmd_set;
    logic [5:0] open_bus;
    logic [1:0] fifo_wr_ptr, fifo_rd_ptr;
    logic       interlace_en, field_odd, legacy_mode, pal_sel, frame_start;
    logic       disp_en, wide_mode, dma_code_bit, region_pal;
    logic [8:0] line, hslot;
    logic [15:0] status_word;
    logic       status_valid, cmd_pending;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit pal_m = 0;
    bit coll_m = 0;

    vstat_word_gen u_vstat_word_gen (.*);

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] expect_word();
        logic [15:0] w;
        int inact;
        inact = legacy_mode ? 192 : (pal_m ? 240 : 224);
        w[15:10] = open_bus;
        w[9] = fifo_empty;
        w[8] = !fifo_empty && (fifo_wr_ptr == fifo_rd_ptr);
        w[7] = vint_pend;
        w[6] = sprite_ovf;
        w[5] = coll_m;
        w[4] = interlace_en && field_odd;
        w[3] = !disp_en || (int'(line) >= inact && int'(line) < 511);
        w[2] = (hslot < 10) || (hslot > (wide_mode ? 165 : 132));
        w[1] = dma_code_bit;
        w[0] = region_pal;
        return w;
    endfunction

    // one read; checks the captured word field by field
    task automatic do_read();
        logic [15:0] e;
        e = expect_word();
        rd_stb = 1'b1;
        if (!coll_set) coll_m = 0;
        @(negedge clk);
        rd_stb = 1'b0;
        chk("R1 open bus",   status_word[15:10], e[15:10]);
        chk("R2 fifo",       status_word[9:8],   e[9:8]);
        chk("R3 vint/ovf",   status_word[7:6],   e[7:6]);
        chk("R4 collision",  status_word[5],     e[5]);
        chk("R5 odd field",  status_word[4],     e[4]);
        chk("R6 vblank",     status_word[3],     e[3]);
        chk("R8 hblank",     status_word[2],     e[2]);
        chk("R9 dma/region", status_word[1:0],   e[1:0]);
        chk("R11 valid",     status_valid,       1);
    endtask

    task automatic frame(bit p);
        pal_sel = p;
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        pal_m = p;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] hold;
        rst_n = 0; rd_stb = 0; open_bus = 0; fifo_empty = 1; fifo_wr_ptr = 0; fifo_rd_ptr = 0;
        vint_pend = 0; sprite_ovf = 0; coll_set = 0; cmd_set = 0; interlace_en = 0;
        field_odd = 0; line = 0; hslot = 50; legacy_mode = 0; pal_sel = 0; frame_start = 0;
        disp_en = 1; wide_mode = 0; dma_code_bit = 0; region_pal = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11 reset state
        chk("R11 reset word", status_word, 0);
        chk("R11 reset valid", status_valid, 0);
        chk("R10 reset pending", cmd_pending, 0);

        // R1 open bus sweep
        for (int b = 0; b < 64; b++) begin
            open_bus = 6'(b);
            do_read();
        end
        // R2 fifo states
        for (int k = 0; k < 32; k++) begin
            fifo_empty = k[4]; fifo_wr_ptr = 2'(k >> 2); fifo_rd_ptr = 2'(k);
            do_read();
        end
        // R3 R5 R9 flag combinations
        for (int k = 0; k < 64; k++) begin
            {vint_pend, sprite_ovf, interlace_en, field_odd, dma_code_bit, region_pal} = 6'(k);
            do_read();
        end
        // R6 line sweep across all vertical modes
        for (int m = 0; m < 3; m++) begin
            legacy_mode = (m == 0);
            frame(m == 2);
            for (int d = 0; d < 2; d++) begin
                disp_en = d[0];
                for (int l = 0; l < 512; l++) begin
                    line = 9'(l);
                    do_read();
                end
            end
        end
        legacy_mode = 0; disp_en = 1;
        // R8 slot sweep in both widths
        for (int w = 0; w < 2; w++) begin
            wide_mode = w[0];
            for (int h = 0; h < 512; h++) begin
                hslot = 9'(h);
                do_read();
            end
        end
        // R7 pal_sel change without frame start is ignored
        frame(0);
        line = 230;
        do_read();
        chk("R7 ntsc frame blank at 230", status_word[3], 1);
        pal_sel = 1;
        @(negedge clk);
        do_read();
        chk("R7 pal_sel ignored mid-frame", status_word[3], 1);
        frame(1);
        do_read();
        chk("R7 pal frame no blank at 230", status_word[3], 0);

        // R4 collision sticky and clear on read
        coll_set = 1; @(negedge clk); coll_set = 0; coll_m = 1;
        repeat (2) @(negedge clk);
        do_read();
        chk("R4 collision first read", status_word[5], 1);
        do_read();
        chk("R4 collision cleared", status_word[5], 0);
        coll_set = 1;
        do_read();
        coll_set = 0; coll_m = 1;
        chk("R4 set with read captures old", status_word[5], 0);
        do_read();
        chk("R4 set wins over read", status_word[5], 1);

        // R10 command pending
        cmd_set = 1; @(negedge clk); cmd_set = 0;
        chk("R10 pending set", cmd_pending, 1);
        do_read();
        chk("R10 pending cleared by read", cmd_pending, 0);
        cmd_set = 1;
        do_read();
        cmd_set = 0;
        chk("R10 set wins over read", cmd_pending, 1);
        do_read();
        chk("R10 cleared again", cmd_pending, 0);

        // R11 word holds without a read
        hold = status_word;
        open_bus = ~open_bus; line = 0; hslot = 300; region_pal = ~region_pal;
        repeat (3) @(negedge clk);
        chk("R11 word held", status_word, hold);
        chk("R11 valid low", status_valid, 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule